// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is an SPI host that carries out whole flash operations on a serial NOR memory for a simple requester. The requester pulses `start` with an operation code, a 24-bit address and a byte count. The block then issues every chip-select framed transaction the operation needs. It puts a separate write-enable transaction in front of any operation that changes the device. After such an operation it polls the device status until the busy flag clears, checks the failure flag, and reports completion with a single-cycle `done` pulse.

Payload data moves over a byte-stream port. The block pulls each program byte from `wr_data` and marks the byte taken with `wr_take`. It hands each received byte out on `rd_data` with a `rd_valid` strobe. The serial clock runs in mode 0: it idles low, MISO is sampled on the rising edge, MOSI changes on the falling edge, and bytes go most significant bit first. Each half period of the serial clock lasts `SCK_HALF` system clocks. Between two transactions, chip select stays high for at least `GAP_SCK` full serial clock periods.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low and `op` is one of 0 (read ID), 1 (unprotect), 2 (chip erase), 3 (program) or 4 (read). A start with any other code, or while busy, has no effect. `busy` stays high from the cycle after acceptance until the cycle in which `done` pulses. A reset returns `cs_n` high, `sclk` low and `busy`, `done`, `err` and `err_tmo` low.
- R2: The serial clock idles low whenever `cs_n` is high. Each high phase and each low phase lasts `SCK_HALF` system clocks. MOSI holds while `sclk` is high, MISO is sampled on the rising edge, and bytes travel most significant bit first.
- R3: Between the end of one transaction and the start of the next, `cs_n` stays high for at least `GAP_SCK*2*SCK_HALF` system clocks.
- R4: Unprotect, chip erase and program are each preceded by a separate transaction that carries only the byte 0x06.
- R5: Unprotect sends the two bytes 0x01, 0x00 in one transaction. Chip erase sends the single byte 0xC7.
- R6: Program sends 0x02, then `addr[23:16]`, `addr[15:8]`, `addr[7:0]`, then `len` bytes taken from `wr_data`. Each byte is consumed in the cycle `wr_take` is high, and `wr_take` is never high outside a program transaction.
- R7: Read sends 0x03 and the three address bytes (high byte first), then clocks 0x00 for `len` more bytes. Each received byte appears on `rd_data` with a one-cycle `rd_valid` while `cs_n` is low.
- R8: Read ID sends 0x9F and delivers the four following response bytes on the read stream.
- R9: After unprotect, erase or program, the block repeats a two-byte transaction 0x05, 0x00, taking the second byte as status. It stops when status bit 0 reads 0. Read and read ID are never followed by polling.
- R10: For program and erase, `err` equals status bit 5 of the final poll. For unprotect, read and read ID, `err` stays 0. If `POLL_MAX` polls in a row read busy, polling stops and `err_tmo` is set instead.
- R11: `done` is a single-cycle pulse issued with `busy` low. `err` and `err_tmo` are valid with it and hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse |
| op | input | 3 | Operation code |
| addr | input | 24 | Flash byte address |
| len | input | LEN_W | Payload byte count for program and read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Program or erase failure reported by the device |
| err_tmo | output | 1 | Busy polling gave up |
| wr_data | input | 8 | Next program byte |
| wr_take | output | 1 | Program byte consumed this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
Assertions watch several properties on every cycle. They check the serial clock idling low while chip select is high, MOSI holding during each high phase, and no byte being launched while one is still shifting. They also check the minimum chip-select high time, and that the read strobe and the program take strobe fire only inside the right frames. Further assertions bound the poll counter and confirm that `done` is a lone pulse given while idle. The bench scenarios show things no single cycle can: the exact byte sequence and framing of every operation, the write-enable prefix, and the number of polls for a given busy duration. They also cover address ordering, read data returned through a device model, and the error and timeout results after a full exchange.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_READ_ID   = 3'd0,
        OP_UNPROTECT = 3'd1,
        OP_ERASE     = 3'd2,
        OP_PROGRAM   = 3'd3,
        OP_READ      = 3'd4
    } flash_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_GAP
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_WREN,
        PH_MAIN,
        PH_POLL
    } seq_phase_e;

    localparam logic [7:0] CMD_WREN  = 8'h06;
    localparam logic [7:0] CMD_WRSR  = 8'h01;
    localparam logic [7:0] CMD_RDSR  = 8'h05;
    localparam logic [7:0] CMD_ERASE = 8'hC7;
    localparam logic [7:0] CMD_PROG  = 8'h02;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_ID    = 8'h9F;

    localparam int ADDR_BYTES = 3;
    localparam int ID_BYTES   = 4;
    localparam int POLL_BYTES = 2;

    function automatic logic needs_wren(flash_op_e o);
        return (o == OP_UNPROTECT) || (o == OP_ERASE) || (o == OP_PROGRAM);
    endfunction

endpackage

// File: rtl/nor_seq_shifter.sv
module nor_seq_shifter #(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);

    localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(SCK_HALF - 1);

    typedef struct packed {
        logic          act;
        logic          sclk;
        logic [CW-1:0] cnt;
        logic [2:0]    bitn;
        logic [7:0]    sh;
        logic [7:0]    rx;
        logic          done;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d      = shf_q;
        shf_d.done = 1'b0;
        if (go && !shf_q.act) begin
            shf_d.act  = 1'b1;
            shf_d.sclk = 1'b0;
            shf_d.cnt  = '0;
            shf_d.bitn = 3'd0;
            shf_d.sh   = tx_byte;
        end else if (shf_q.act) begin
            if (shf_q.cnt == CNT_LAST) begin
                shf_d.cnt = '0;
                if (!shf_q.sclk) begin
                    shf_d.sclk = 1'b1;
                    shf_d.rx   = {shf_q.rx[6:0], miso};
                end else begin
                    shf_d.sclk = 1'b0;
                    if (shf_q.bitn == 3'd7) begin
                        shf_d.act  = 1'b0;
                        shf_d.done = 1'b1;
                    end else begin
                        shf_d.bitn = shf_q.bitn + 3'd1;
                        shf_d.sh   = {shf_q.sh[6:0], 1'b0};
                    end
                end
            end else begin
                shf_d.cnt = shf_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign sclk      = shf_q.sclk;
    assign mosi      = shf_q.sh[7];
    assign rx_byte   = shf_q.rx;
    assign byte_done = shf_q.done;

    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shf_q.sclk |-> $stable(mosi));

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !shf_q.act);

endmodule

// File: rtl/nor_seq_gap_timer.sv
module nor_seq_gap_timer #(
    parameter int GAP_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int GW = $clog2(GAP_CYC + 1);

    typedef struct packed {
        logic [GW-1:0] cnt;
    } gap_t;

    gap_t gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (load)                 gap_d.cnt = GW'(GAP_CYC);
        else if (gap_q.cnt != '0) gap_d.cnt = gap_q.cnt - GW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= '0;
        else        gap_q <= gap_d;
    end

    assign expired = (gap_q.cnt == '0);

    assert_gap_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && gap_q.cnt != '0) |=> (gap_q.cnt == $past(gap_q.cnt) - GW'(1)));

endmodule

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer
    import nor_seq_pkg::*;
#(
    parameter int SCK_HALF = 2,
    parameter int GAP_SCK  = 2,
    parameter int POLL_MAX = 100000,
    parameter int LEN_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [23:0]      addr,
    input  logic [LEN_W-1:0] len,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             err_tmo,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);

    localparam int GAP_CYC = GAP_SCK * 2 * SCK_HALF;
    localparam int PW      = $clog2(POLL_MAX + 1);
    localparam int NW      = LEN_W + 1;
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_MAX - 1);
    localparam logic [NW-1:0] HDR_BYTES = NW'(ADDR_BYTES + 1);

    typedef struct packed {
        seq_state_e       st;
        seq_phase_e       ph;
        flash_op_e        op;
        logic [23:0]      addr;
        logic [LEN_W-1:0] len;
        logic [NW-1:0]    idx;
        logic [PW-1:0]    polls;
        logic             stat_busy;
        logic             stat_fail;
        logic             done;
        logic             err;
        logic             tmo;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          go;
    logic [7:0]    tx_sel;
    logic [7:0]    rx_byte;
    logic          byte_done;
    logic          gap_load;
    logic          gap_expired;
    logic [NW-1:0] frame_len;
    logic          last_byte;
    logic          op_ok;
    logic          payload_idx;
    logic          finish;

    nor_seq_shifter #(.SCK_HALF(SCK_HALF)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .tx_byte   (tx_sel),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .rx_byte   (rx_byte),
        .byte_done (byte_done)
    );

    nor_seq_gap_timer #(.GAP_CYC(GAP_CYC)) gap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .expired (gap_expired)
    );

    assign op_ok       = (op <= 3'd4);
    assign payload_idx = (ctl_q.idx >= HDR_BYTES);

    // Bytes in the current frame
    always_comb begin
        frame_len = NW'(1);
        unique case (ctl_q.ph)
            PH_WREN: frame_len = NW'(1);
            PH_POLL: frame_len = NW'(POLL_BYTES);
            default: begin
                unique case (ctl_q.op)
                    OP_READ_ID:   frame_len = NW'(ID_BYTES + 1);
                    OP_UNPROTECT: frame_len = NW'(2);
                    OP_ERASE:     frame_len = NW'(1);
                    default:      frame_len = HDR_BYTES + NW'(ctl_q.len);
                endcase
            end
        endcase
    end

    assign last_byte = (ctl_q.idx == frame_len - NW'(1));

    // Byte to launch at the current index
    always_comb begin
        tx_sel = 8'h00;
        unique case (ctl_q.ph)
            PH_WREN: tx_sel = CMD_WREN;
            PH_POLL: tx_sel = (ctl_q.idx == '0) ? CMD_RDSR : 8'h00;
            default: begin
                if (ctl_q.idx == '0) begin
                    unique case (ctl_q.op)
                        OP_READ_ID:   tx_sel = CMD_ID;
                        OP_UNPROTECT: tx_sel = CMD_WRSR;
                        OP_ERASE:     tx_sel = CMD_ERASE;
                        OP_PROGRAM:   tx_sel = CMD_PROG;
                        default:      tx_sel = CMD_READ;
                    endcase
                end else if (ctl_q.op == OP_PROGRAM || ctl_q.op == OP_READ) begin
                    if (ctl_q.idx == NW'(1))      tx_sel = ctl_q.addr[23:16];
                    else if (ctl_q.idx == NW'(2)) tx_sel = ctl_q.addr[15:8];
                    else if (ctl_q.idx == NW'(3)) tx_sel = ctl_q.addr[7:0];
                    else if (ctl_q.op == OP_PROGRAM) tx_sel = wr_data;
                end
            end
        endcase
    end

    assign go      = (ctl_q.st == ST_LOAD);
    assign wr_take = go && (ctl_q.ph == PH_MAIN) && (ctl_q.op == OP_PROGRAM) && payload_idx;

    assign rd_data  = rx_byte;
    assign rd_valid = (ctl_q.st == ST_WAIT) && byte_done && (ctl_q.ph == PH_MAIN) &&
                      (((ctl_q.op == OP_READ_ID) && (ctl_q.idx != '0)) ||
                       ((ctl_q.op == OP_READ) && payload_idx));

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        gap_load   = 1'b0;
        finish     = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start && op_ok) begin
                    ctl_d.op    = flash_op_e'(op);
                    ctl_d.addr  = addr;
                    ctl_d.len   = len;
                    ctl_d.idx   = '0;
                    ctl_d.polls = '0;
                    ctl_d.err   = 1'b0;
                    ctl_d.tmo   = 1'b0;
                    ctl_d.ph    = needs_wren(flash_op_e'(op)) ? PH_WREN : PH_MAIN;
                    ctl_d.st    = ST_LOAD;
                end
            end
            ST_LOAD: ctl_d.st = ST_WAIT;
            ST_WAIT: begin
                if (byte_done) begin
                    if (ctl_q.ph == PH_POLL && ctl_q.idx == NW'(1)) begin
                        ctl_d.stat_busy = rx_byte[0];
                        ctl_d.stat_fail = rx_byte[5];
                    end
                    if (last_byte) begin
                        ctl_d.st = ST_GAP;
                        gap_load = 1'b1;
                    end else begin
                        ctl_d.idx = ctl_q.idx + NW'(1);
                        ctl_d.st  = ST_LOAD;
                    end
                end
            end
            default: begin
                if (gap_expired) begin
                    ctl_d.idx = '0;
                    unique case (ctl_q.ph)
                        PH_WREN: begin
                            ctl_d.ph = PH_MAIN;
                            ctl_d.st = ST_LOAD;
                        end
                        PH_MAIN: begin
                            if (needs_wren(ctl_q.op)) begin
                                ctl_d.ph = PH_POLL;
                                ctl_d.st = ST_LOAD;
                            end else begin
                                finish = 1'b1;
                            end
                        end
                        default: begin
                            if (ctl_q.stat_busy) begin
                                if (ctl_q.polls == POLL_LAST) begin
                                    ctl_d.tmo = 1'b1;
                                    finish    = 1'b1;
                                end else begin
                                    ctl_d.polls = ctl_q.polls + PW'(1);
                                    ctl_d.st    = ST_LOAD;
                                end
                            end else begin
                                ctl_d.err = ctl_q.stat_fail &&
                                            (ctl_q.op == OP_ERASE || ctl_q.op == OP_PROGRAM);
                                finish    = 1'b1;
                            end
                        end
                    endcase
                    if (finish) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy    = (ctl_q.st != ST_IDLE);
    assign done    = ctl_q.done;
    assign err     = ctl_q.err;
    assign err_tmo = ctl_q.tmo;
    assign cs_n    = !((ctl_q.st == ST_LOAD) || (ctl_q.st == ST_WAIT));

    // Checker state: length of the current chip-select high run
    localparam int HW = $clog2(GAP_CYC + 1);
    logic [HW-1:0] hi_run_q;
    logic          framed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q <= '0;
            framed_q <= 1'b0;
        end else begin
            if (!cs_n)                         hi_run_q <= '0;
            else if (hi_run_q != HW'(GAP_CYC)) hi_run_q <= hi_run_q + HW'(1);
            if (!cs_n) framed_q <= 1'b1;
        end
    end

    assert_cs_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(cs_n) && framed_q) |-> (hi_run_q >= HW'(GAP_CYC)));

    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_rd_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !cs_n);

    assert_take_program_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (!cs_n && ctl_q.op == OP_PROGRAM));

    assert_poll_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.polls < PW'(POLL_MAX));

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy) && $past(rst_n)) |-> $past(start && op_ok));

endmodule

// File: tb/nor_cmd_sequencer_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_sequencer_tb_top;

    localparam int SCK_HALF = 2;
    localparam int GAP_SCK  = 2;
    localparam int POLL_MAX = 4;
    localparam int LEN_W    = 9;
    localparam int GAP_CYC  = GAP_SCK * 2 * SCK_HALF;
    localparam int WD_LIMIT = 150000;

    // vector: {op[2:0], addr[23:0], len[8:0], busy_polls[3:0], fail_inject}
    localparam int NVEC = 9;
    localparam logic [40:0] VEC [NVEC] = '{
        {3'd0, 24'h000000, 9'd0, 4'd0, 1'b0},
        {3'd1, 24'h000000, 9'd0, 4'd1, 1'b1},
        {3'd2, 24'h000000, 9'd0, 4'd3, 1'b0},
        {3'd3, 24'h123456, 9'd6, 4'd2, 1'b0},
        {3'd4, 24'h123456, 9'd5, 4'd0, 1'b0},
        {3'd3, 24'hAB00FF, 9'd3, 4'd0, 1'b1},
        {3'd2, 24'h000000, 9'd0, 4'd6, 1'b0},
        {3'd4, 24'hFFFFFE, 9'd0, 4'd0, 1'b0},
        {3'd3, 24'h00F0A5, 9'd0, 4'd1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] op = 3'd0;
    logic [23:0] addr = '0;
    logic [LEN_W-1:0] len = '0;
    logic busy, done, err, err_tmo;
    logic [7:0] wr_data;
    logic wr_take;
    logic [7:0] rd_data;
    logic rd_valid;
    logic sclk, cs_n, mosi;
    logic miso = 1'b0;

    always #4 clk = ~clk;

    nor_cmd_sequencer #(
        .SCK_HALF(SCK_HALF), .GAP_SCK(GAP_SCK), .POLL_MAX(POLL_MAX), .LEN_W(LEN_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .len(len),
        .busy(busy), .done(done), .err(err), .err_tmo(err_tmo),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit wd     = 1'b0;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [7:0] mlog [0:1023];
    int         flen [0:255];
    int mlog_n = 0, fcnt = 0, fstart = 0;
    int bcnt = 0, bidx = 0, busy_left = 0, m_busy_init = 0;
    logic [7:0] in_sh = '0, out_sh = '0, cmd = '0;
    logic [23:0] maddr = '0;
    logic errf = 1'b0, m_err_init = 1'b0;

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] id_byte(input int i);
        case (i)
            0: return 8'hC2;
            1: return 8'h31;
            2: return 8'h17;
            default: return 8'h05;
        endcase
    endfunction

    always @(negedge cs_n) begin
        bcnt = 0; bidx = 0; out_sh = 8'h00;
    end

    always @(posedge sclk) if (!cs_n) begin
        in_sh = {in_sh[6:0], mosi};
        bcnt++;
        if (bcnt == 8) begin
            bcnt = 0;
            mlog[mlog_n] = in_sh;
            mlog_n++;
            if (bidx == 0) cmd = in_sh;
            out_sh = 8'h00;
            case (cmd)
                8'h9F: if (bidx < 4) out_sh = id_byte(bidx);
                8'h05: out_sh = {2'b00, errf, 4'b0000, (busy_left > 0)};
                8'h03: begin
                    if (bidx >= 1 && bidx <= 3) maddr = {maddr[15:0], in_sh};
                    if (bidx >= 3) out_sh = mem_byte(maddr + 24'(bidx - 3));
                end
                default: out_sh = 8'h00;
            endcase
            bidx++;
        end
    end

    always @(negedge sclk) if (!cs_n) begin
        miso = out_sh[7];
        out_sh = {out_sh[6:0], 1'b0};
    end

    always @(posedge cs_n) begin
        if (mlog_n != fstart) begin
            flen[fcnt] = mlog_n - fstart;
            fcnt++;
            fstart = mlog_n;
            if (cmd == 8'h05) begin
                if (busy_left > 0) busy_left--;
            end else if (cmd == 8'h02 || cmd == 8'hC7 || cmd == 8'h01) begin
                busy_left = m_busy_init;
                errf = m_err_init;
            end
        end
    end

    // ---------------- requester side ----------------
    int wr_total = 0;
    int rd_total = 0;
    logic [7:0] rdlog [0:255];
    assign wr_data = 8'h30 + 8'(wr_total);

    always @(posedge clk) begin
        if (wr_take) wr_total++;
        if (rd_valid) begin
            rdlog[rd_total] = rd_data;
            rd_total++;
        end
    end

    // ---------------- line timing monitors ----------------
    int hi_run = 0, min_gap = 1000000, sck_hi = 0, sck_min = 1000, sck_max = 0;
    bit seen_frame = 1'b0;
    always @(negedge clk) if (rst_n) begin
        if (cs_n) hi_run++;
        else begin
            if (hi_run > 0 && seen_frame && hi_run < min_gap) min_gap = hi_run;
            hi_run = 0;
            seen_frame = 1'b1;
        end
        if (sclk) sck_hi++;
        else if (sck_hi > 0) begin
            if (sck_hi < sck_min) sck_min = sck_hi;
            if (sck_hi > sck_max) sck_max = sck_hi;
            sck_hi = 0;
        end
    end

    // ---------------- expected frames ----------------
    logic [7:0] eb [0:511];
    int ef [0:63];
    int ne = 0, nf = 0, fb = 0;

    task automatic push(input logic [7:0] b);
        eb[ne] = b; ne++;
    endtask

    task automatic endf();
        ef[nf] = ne - fb; nf++; fb = ne;
    endtask

    task automatic wait_done();
        while (!done) begin
            @(negedge clk);
            if (cyc > WD_LIMIT) begin wd = 1'b1; break; end
        end
    endtask

    task automatic run_op(input logic [2:0] o, input logic [23:0] a, input int n,
                          input int bp, input bit ei, input bit busy_poke);
        int b0, f0, w0, r0, np;
        bit exp_tmo, exp_err, ok;
        b0 = mlog_n; f0 = fcnt; w0 = wr_total; r0 = rd_total;
        m_busy_init = bp; m_err_init = ei;
        ne = 0; nf = 0; fb = 0;
        if (o == 3'd1 || o == 3'd2 || o == 3'd3) begin push(8'h06); endf(); end
        case (o)
            3'd0: begin push(8'h9F); for (int i = 0; i < 4; i++) push(8'h00); end
            3'd1: begin push(8'h01); push(8'h00); end
            3'd2: push(8'hC7);
            3'd3: begin
                push(8'h02); push(a[23:16]); push(a[15:8]); push(a[7:0]);
                for (int i = 0; i < n; i++) push(8'h30 + 8'(w0 + i));
            end
            default: begin
                push(8'h03); push(a[23:16]); push(a[15:8]); push(a[7:0]);
                for (int i = 0; i < n; i++) push(8'h00);
            end
        endcase
        endf();
        exp_tmo = 1'b0;
        if (o == 3'd1 || o == 3'd2 || o == 3'd3) begin
            exp_tmo = (bp >= POLL_MAX);
            np = exp_tmo ? POLL_MAX : bp + 1;
            for (int i = 0; i < np; i++) begin push(8'h05); push(8'h00); endf(); end
        end
        exp_err = !exp_tmo && ei && (o == 3'd2 || o == 3'd3);

        @(negedge clk);
        start = 1'b1; op = o; addr = a; len = LEN_W'(n);
        @(negedge clk);
        start = 1'b0;
        if (busy_poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1; op = 3'd2;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done();

        // R4 R5 R6 R7 R8 R9: frame structure and bytes
        ok = (fcnt - f0 == nf) && (mlog_n - b0 == ne);
        for (int i = 0; ok && i < nf; i++) ok = (flen[f0 + i] == ef[i]);
        for (int i = 0; ok && i < ne; i++) ok = (mlog[b0 + i] == eb[i]);
        check(ok, "R4/R5/R6/R9", $sformatf("op %0d frames", o), fcnt - f0, nf);
        check(wr_total - w0 == ((o == 3'd3) ? n : 0), "R6", "bytes taken", wr_total - w0,
              (o == 3'd3) ? n : 0);
        if (o == 3'd0) begin
            ok = (rd_total - r0 == 4);
            for (int i = 0; ok && i < 4; i++) ok = (rdlog[r0 + i] == id_byte(i));
            check(ok, "R8", "id bytes", rd_total - r0, 4);
        end else if (o == 3'd4) begin
            ok = (rd_total - r0 == n);
            for (int i = 0; ok && i < n; i++) ok = (rdlog[r0 + i] == mem_byte(a + 24'(i)));
            check(ok, "R7", "read bytes", rd_total - r0, n);
        end
        check(err == exp_err, "R10", "err", err, exp_err);
        check(err_tmo == exp_tmo, "R10", "timeout", err_tmo, exp_tmo);
        check(!busy, "R11", "busy at done", busy, 0);
        @(negedge clk);
        check(!done && err == exp_err && err_tmo == exp_tmo, "R11", "done pulse and hold",
              {done, err, err_tmo}, {1'b0, exp_err, exp_tmo});
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int f0;
        repeat (4) @(negedge clk);
        check(cs_n && !sclk && !busy && !done && !err && !err_tmo, "R1", "reset state",
              {cs_n, sclk, busy, done, err, err_tmo}, 6'b100000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            run_op(VEC[v][40:38], VEC[v][37:14], int'(VEC[v][13:5]),
                   int'(VEC[v][4:1]), VEC[v][0], 1'b0);
        end

        // R1: unsupported code is ignored
        f0 = fcnt;
        @(negedge clk); start = 1'b1; op = 3'd6;
        @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        check(!busy && fcnt == f0 && cs_n, "R1", "bad op ignored", fcnt - f0, 0);

        // R1: start while busy is ignored (read runs alone, no erase follows)
        run_op(3'd4, 24'h000010, 2, 0, 1'b0, 1'b1);

        // R3 / R2: line timing
        check(min_gap >= GAP_CYC, "R3", "min cs high", min_gap, GAP_CYC);
        check(sck_min == SCK_HALF && sck_max == SCK_HALF, "R2", "sclk high width",
              sck_max, SCK_HALF);

        // R1: reset in the middle of a program
        @(negedge clk); start = 1'b1; op = 3'd3; addr = 24'h000100; len = 9'd4;
        @(negedge clk); start = 1'b0;
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(cs_n && !sclk && !busy, "R1", "reset mid program", {cs_n, sclk, busy}, 3'b100);
        @(negedge clk); rst_n = 1'b1;
        repeat (20) @(negedge clk);
        run_op(3'd4, 24'h0A0B0C, 3, 0, 1'b0, 1'b0);

        if (wd) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT + 20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule